// File: doc/BRIEF.md
# Pipelined Bitonic Merge Network

This block combines two sorted lists of equal length into one list sorted from smallest to largest. The two lists come in together as a single parallel vector. The lower half of the vector holds the first list in ascending order. The upper half holds the second list in descending order. Because the two halves run in opposite directions, the whole vector is a bitonic sequence, and a butterfly of compare-exchange cells can finish the merge in log2 of the length in steps.

Each of the `LOG2N` stages works the same way. It first applies a perfect-shuffle interleave to the vector, then runs a column of two-input sorters across adjacent pairs, and then registers the result. A valid flag moves down a register chain that stays aligned with the data. The block can take a new vector on every clock cycle and returns each merged vector exactly `LOG2N` cycles later. Two parameters are available:
- One picks whether the magnitude comparator is a bit-serial greater-than/equality chain or a single relational operator.
- The other picks whether the data registers load only when valid data is present.

Top module: `bitonic_merge_pipe`

## Requirements
- R1: Element `i` of either vector sits in bits `[i*W +: W]`. Given a valid input whose elements 0 to N/2-1 are non-decreasing and whose elements N/2 to N-1 are non-increasing, every output element `i` is less than or equal to output element `i+1`.
- R2: The output vector holds the same multiset of values as the input vector that produced it, including repeated and all-equal values.
- R3: `out_valid` is high exactly `LOG2N` clock edges after the edge that samples `in_valid` high, and `out_data` carries that vector's result in the same cycle.
- R4: Inputs on consecutive cycles are accepted with no stall. Each result comes out in input order on consecutive cycles.
- R5: A synchronous active-high `rst` sampled at a clock edge leaves `out_valid` low after that edge. Any vector still in the pipeline at that time never produces `out_valid`.
- R6: Elements are compared as unsigned numbers, so a value with its top bit set sorts above every value with its top bit clear.
- R7: A cycle with `in_valid` low gives a cycle with `out_valid` low `LOG2N` edges later, even between valid vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid chain |
| in_valid | input | 1 | Marks `in_data` as a vector to merge |
| in_data | input | N*W | Lower half ascending list, upper half descending list |
| out_valid | output | 1 | Marks `out_data` as a merged result |
| out_data | output | N*W | Merged vector, element 0 smallest |

## Verification
The merge is exercised with several kinds of input:
- **Random opposed-order lists.** These check the general sorting function.
- **Lists whose halves overlap heavily or are all one value.** These show whether ties lose or duplicate values when the sorters pick arbitrarily.
- **Vectors that mix zero, the all-ones value and values around the top bit.** These separate unsigned ordering from signed ordering.
- **Back-to-back streams with bubbles in between.** These catch a valid chain that is misaligned with the data or that fills gaps with stale data.
- **A reset applied while a vector is in flight.** This shows that the pending result is dropped rather than only delayed.

// File: rtl/bmn_pkg.sv
package bmn_pkg;

   // Perfect-shuffle source index for output position idx over 2*half elements.
   function automatic int shuffle_src(input int idx, input int half);
      if ((idx % 2) == 0) return idx / 2;
      else return half + idx / 2;
   endfunction

   typedef enum logic {CMP_BEHAV = 1'b0, CMP_CHAIN = 1'b1} cmp_style_e;

endpackage

// File: rtl/bmn_mag_cmp.sv
module bmn_mag_cmp #(
   parameter int                  W     = 8,
   parameter bmn_pkg::cmp_style_e STYLE = bmn_pkg::CMP_CHAIN
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         a_gt_b
);
   initial begin
      if (W < 1) $error("bmn_mag_cmp: W must be at least 1");
   end

   generate
      if (STYLE == bmn_pkg::CMP_CHAIN) begin : g_chain
         // Scan from the most significant bit: greater once a differing bit favours a.
         logic [W:0] gt_c;
         logic [W:1] eq_c;
         assign gt_c[W] = 1'b0;
         for (genvar i = W - 1; i >= 0; i--) begin : g_bit
            if (i == W - 1) begin : g_top
               assign gt_c[i] = a[i] & ~b[i];
               if (i > 0) begin : g_eq
                  assign eq_c[i] = ~(a[i] ^ b[i]);
               end
            end else begin : g_low
               assign gt_c[i] = gt_c[i+1] | (eq_c[i+1] & a[i] & ~b[i]);
               if (i > 0) begin : g_eq
                  assign eq_c[i] = eq_c[i+1] & ~(a[i] ^ b[i]);
               end
            end
         end
         assign a_gt_b = gt_c[0];
      end else begin : g_behav
         assign a_gt_b = (a > b);
      end
   endgenerate

endmodule

// File: rtl/bmn_cas.sv
module bmn_cas #(
   parameter int                  W     = 8,
   parameter bmn_pkg::cmp_style_e STYLE = bmn_pkg::CMP_CHAIN
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi
);
   logic swap;

   bmn_mag_cmp #(.W(W), .STYLE(STYLE)) u_cmp (
      .a      (a),
      .b      (b),
      .a_gt_b (swap)
   );

   assign lo = swap ? b : a;
   assign hi = swap ? a : b;

endmodule

// File: rtl/bmn_stage.sv
module bmn_stage #(
   parameter int                  W      = 8,
   parameter int                  N      = 8,
   parameter bmn_pkg::cmp_style_e STYLE  = bmn_pkg::CMP_CHAIN,
   parameter bit                  GATED  = 1'b1
) (
   input  logic           clk,
   input  logic           en,
   input  logic [N*W-1:0] d_in,
   output logic [N*W-1:0] d_out
);
   localparam int HALF = N / 2;

   initial begin
      if (N < 2 || (N % 2) != 0) $error("bmn_stage: N must be even and at least 2");
   end

   logic [N*W-1:0] shuf;
   logic [N*W-1:0] col;

   // Fixed interleave: even slots from the lower half, odd slots from the upper half.
   for (genvar i = 0; i < N; i++) begin : g_shuf
      localparam int SRC = bmn_pkg::shuffle_src(i, HALF);
      assign shuf[i*W +: W] = d_in[SRC*W +: W];
   end

   // Column of compare-exchange cells on adjacent pairs, minimum to the lower slot.
   for (genvar j = 0; j < HALF; j++) begin : g_col
      bmn_cas #(.W(W), .STYLE(STYLE)) u_cas (
         .a  (shuf[(2*j)*W +: W]),
         .b  (shuf[(2*j+1)*W +: W]),
         .lo (col[(2*j)*W +: W]),
         .hi (col[(2*j+1)*W +: W])
      );
   end

   generate
      if (GATED) begin : g_gated
         always_ff @(posedge clk) begin
            if (en) d_out <= col;
         end
      end else begin : g_free
         logic unused_en;
         assign unused_en = en;
         always_ff @(posedge clk) begin
            d_out <= col;
         end
      end
   endgenerate

endmodule

// File: rtl/bitonic_merge_pipe.sv
module bitonic_merge_pipe #(
   parameter int                  W         = 8,
   parameter int                  LOG2N     = 3,
   parameter bmn_pkg::cmp_style_e CMP_STYLE = bmn_pkg::CMP_CHAIN,
   parameter bit                  GATE_DATA = 1'b1,
   localparam int                 N         = 1 << LOG2N
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   input  logic [N*W-1:0] in_data,
   output logic           out_valid,
   output logic [N*W-1:0] out_data
);
   initial begin
      if (W < 1 || W > 64) $error("bitonic_merge_pipe: W out of range 1..64");
      if (LOG2N < 1 || LOG2N > 6) $error("bitonic_merge_pipe: LOG2N out of range 1..6");
   end

   logic [N*W-1:0] stg [LOG2N+1];
   logic [LOG2N-1:0] vld;

   assign stg[0] = in_data;

   for (genvar s = 0; s < LOG2N; s++) begin : g_stage
      logic en_s;
      if (s == 0) begin : g_first
         assign en_s = in_valid;
      end else begin : g_rest
         assign en_s = vld[s-1];
      end
      bmn_stage #(.W(W), .N(N), .STYLE(CMP_STYLE), .GATED(GATE_DATA)) u_stage (
         .clk   (clk),
         .en    (en_s),
         .d_in  (stg[s]),
         .d_out (stg[s+1])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld <= '0;
      end else begin
         vld[0] <= in_valid;
         for (int s = 1; s < LOG2N; s++) vld[s] <= vld[s-1];
      end
   end

   assign out_valid = vld[LOG2N-1];
   assign out_data  = stg[LOG2N];

endmodule

// File: rtl/bmn_checker.sv
module bmn_checker #(
   parameter int W     = 8,
   parameter int LOG2N = 3,
   localparam int N    = 1 << LOG2N,
   localparam int SW   = W + LOG2N
) (
   input logic           clk,
   input logic           rst,
   input logic           in_valid,
   input logic [N*W-1:0] in_data,
   input logic           out_valid,
   input logic [N*W-1:0] out_data
);
   logic [LOG2N-1:0] v_h;
   logic [SW-1:0]    sum_h [LOG2N];
   logic [SW-1:0]    in_sum, out_sum;
   logic             out_sorted;
   logic             rst_q;

   always_comb begin
      in_sum  = '0;
      out_sum = '0;
      out_sorted = 1'b1;
      for (int i = 0; i < N; i++) begin
         in_sum  = in_sum  + SW'(in_data[i*W +: W]);
         out_sum = out_sum + SW'(out_data[i*W +: W]);
      end
      for (int i = 0; i < N - 1; i++) begin
         if (out_data[i*W +: W] > out_data[(i+1)*W +: W]) out_sorted = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) v_h <= '0;
      else begin
         v_h[0] <= in_valid;
         for (int s = 1; s < LOG2N; s++) v_h[s] <= v_h[s-1];
      end
      sum_h[0] <= in_sum;
      for (int s = 1; s < LOG2N; s++) sum_h[s] <= sum_h[s-1];
   end

   // R1 / R6: results leave in non-decreasing unsigned order
   p_sorted_r1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_sorted);

   // R2: value total preserved across the pipeline
   p_sum_kept_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_sum == sum_h[LOG2N-1]));

   // R3 / R7: output valid tracks input valid LOG2N edges earlier
   p_latency_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid == v_h[LOG2N-1]);

   // R5: reset at an edge leaves no valid output after it
   always_ff @(posedge clk) begin
      if (rst_q) p_reset_clear_r5: assert (!out_valid);
   end

endmodule

bind bitonic_merge_pipe bmn_checker #(.W(W), .LOG2N(LOG2N)) u_chk (.*);

// File: tb/sim_bitonic_merge_pipe.sv
module sim_bitonic_merge_pipe;
   localparam int W = 8;
   localparam int K = 3;
   localparam int N = 1 << K;
   localparam int H = N / 2;
   localparam int MAXV = 16;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           in_valid = 1'b0;
   logic [N*W-1:0] in_data = '0;
   logic           out_valid;
   logic [N*W-1:0] out_data;

   int n_chk = 0;
   int n_bad = 0;

   logic [N*W-1:0] stim [MAXV];
   logic           sv   [MAXV];

   always #5 clk = ~clk;

   bitonic_merge_pipe #(.W(W), .LOG2N(K)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
      logic [W-1:0] a [N];
      logic [W-1:0] t;
      logic [N*W-1:0] r;
      for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N - 1 - i; j++)
            if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
      for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
      return r;
   endfunction

   // Build the opposed-order layout from an arbitrary list of values.
   function automatic logic [N*W-1:0] opposed(input logic [N*W-1:0] v);
      logic [N*W-1:0] lo_s, hi_s, r;
      lo_s = '0; hi_s = '0;
      for (int i = 0; i < H; i++) begin
         lo_s[i*W +: W] = v[i*W +: W];
         hi_s[i*W +: W] = v[(H+i)*W +: W];
      end
      lo_s = ref_sort(lo_s);
      hi_s = ref_sort(hi_s);
      for (int i = 0; i < H; i++) begin
         r[i*W +: W]     = lo_s[(N-H+i)*W +: W];
         r[(H+i)*W +: W] = hi_s[(N-1-i)*W +: W];
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [N*W-1:0] act,
                        input logic [N*W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive cnt slots from stim/sv back to back, check each slot K cycles later.
   task automatic run_stream(input string req, input int cnt);
      for (int c = 0; c < cnt + K; c++) begin
         @(negedge clk);
         if (c >= K) begin
            check({req, " valid"}, {{(N*W-1){1'b0}}, out_valid},
                  {{(N*W-1){1'b0}}, sv[c-K]});
            if (sv[c-K]) check({req, " data"}, out_data, ref_sort(stim[c-K]));
         end
         if (c < cnt) begin
            in_valid = sv[c];
            in_data  = stim[c];
         end else begin
            in_valid = 1'b0;
            in_data  = '0;
         end
      end
   endtask

   task automatic t_reset_state;
      check("R5 reset state", {{(N*W-1){1'b0}}, out_valid}, '0);
   endtask

   task automatic t_random;
      for (int i = 0; i < 6; i++) begin
         logic [N*W-1:0] raw;
         for (int e = 0; e < N; e++) raw[e*W +: W] = W'($urandom);
         stim[i] = opposed(raw); sv[i] = 1'b1;
      end
      run_stream("R1 R3 random", 6);
   endtask

   task automatic t_dups;
      logic [N*W-1:0] raw;
      for (int e = 0; e < N; e++) raw[e*W +: W] = 8'h5A;
      stim[0] = raw; sv[0] = 1'b1;
      for (int e = 0; e < N; e++) raw[e*W +: W] = W'(e % 3);
      stim[1] = opposed(raw); sv[1] = 1'b1;
      for (int e = 0; e < N; e++) raw[e*W +: W] = (e < H) ? 8'd7 : W'(e);
      stim[2] = opposed(raw); sv[2] = 1'b1;
      run_stream("R2 duplicates", 3);
   endtask

   task automatic t_unsigned;
      logic [N*W-1:0] raw;
      raw = {8'hFF, 8'h80, 8'h7F, 8'h00, 8'h81, 8'h01, 8'hFE, 8'h7E};
      stim[0] = opposed(raw); sv[0] = 1'b1;
      raw = {8'h80, 8'h80, 8'h80, 8'h80, 8'h7F, 8'h7F, 8'h7F, 8'h7F};
      stim[1] = opposed(raw); sv[1] = 1'b1;
      run_stream("R6 unsigned", 2);
   endtask

   task automatic t_bubbles;
      for (int i = 0; i < 8; i++) begin
         logic [N*W-1:0] raw;
         for (int e = 0; e < N; e++) raw[e*W +: W] = W'($urandom);
         stim[i] = opposed(raw);
         sv[i]   = (i % 3) != 1;
      end
      run_stream("R4 R7 bubbles", 8);
   endtask

   task automatic t_reset_flight;
      logic [N*W-1:0] raw;
      for (int e = 0; e < N; e++) raw[e*W +: W] = W'(e * 17);
      @(negedge clk);
      in_valid = 1'b1; in_data = opposed(raw);
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      check("R5 after reset edge", {{(N*W-1){1'b0}}, out_valid}, '0);
      rst = 1'b0;
      for (int c = 0; c < K + 1; c++) begin
         @(negedge clk);
         check("R5 flushed", {{(N*W-1){1'b0}}, out_valid}, '0);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_random();
      t_dups();
      t_unsigned();
      t_bubbles();
      t_reset_flight();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule